// File: doc/BRIEF.md
# Crosspoint Configuration Loader

This block assembles the control word of an eight-output crosspoint switch. The word is 32 bits wide and is split into eight 4-bit fields, one per output. In each field, bits 2:0 name the input routed to that output, with bit 0 as the least significant bit, and bit 3 turns the output on. The decoders, the update latch and the switch array sit downstream and read the assembled word.

Two load paths share the same register, and a mode pin chooses between them. In serial mode, each falling clock edge shifts one bit in at the bottom of the word. The oldest bit leaves at the top on a serial output, so several loaders can be chained one after another. In parallel mode, a 4-bit value is written into one field picked by a 3-bit address, and the other seven fields are left as they were. This lets one output be rerouted without resending the whole word. An active-low chip enable gates both paths.

Top module: `xpt_cfg_loader`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no load performed, `word_o` is all zeros and `ser_o` is 0.
- R2: At a falling edge of `clk_i` where `ce_ni` is 1, `word_o` and `ser_o` keep their values. This holds in both modes and whatever the data and address inputs carry.
- R3: At a falling edge where `ce_ni` is 0 and `par_mode_i` is 0 (serial), `word_o` shifts left by one place and takes `ser_i` into bit 0. Rising edges never change `word_o`.
- R4: While `par_mode_i` is 0, `ser_o` equals bit 31 of `word_o`. A bit shifted in therefore reaches `ser_o` after 32 serial falling edges.
- R5: Field k occupies bits 4k+3 down to 4k. After 32 serial shifts, the first bit sent sits in bit 3 of field 7 (bit 31) and the last bit sent sits in bit 0 of field 0 (bit 0). The word is thus sent most significant bit first.
- R6: At a falling edge where `ce_ni` is 0 and `par_mode_i` is 1 (parallel), field `addr_i` takes `nib_i` and all other fields keep their values.
- R7: While `par_mode_i` is 1, `ser_o` holds the value it had at the last falling edge in serial mode, even when a parallel write changes bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Load clock, falling edge active |
| rst_ni | input | 1 | Asynchronous active-low initialisation of the register |
| ce_ni | input | 1 | Chip enable, active low; loading occurs only when low |
| par_mode_i | input | 1 | 0 = serial load, 1 = parallel addressed write |
| ser_i | input | 1 | Serial data in |
| nib_i | input | 4 | Parallel field value (bit 3 enable, bits 2:0 input select) |
| addr_i | input | 3 | Parallel field address (output number) |
| ser_o | output | 1 | Serial data out, for chaining |
| word_o | output | 32 | Assembled control word |

## Verification
Every register in the block updates at the falling edge. A load applied before a falling edge is therefore visible on `word_o` and `ser_o` right after that edge. The bench drives its inputs just after a rising edge, lets one falling edge pass, and samples one nanosecond after the next rising edge, so each check compares against the bench model exactly one load later. For the serial path, a bit sent in is expected at `ser_o` 32 falling edges later, and the bench checks the whole output stream bit by bit during a second full load.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  parameter int unsigned XPT_NUM_OUT = 8;

  typedef enum logic {
    LOAD_SER = 1'b0,
    LOAD_PAR = 1'b1
  } load_mode_e;
endpackage

// File: rtl/xpt_cfg_field.sv
module xpt_cfg_field #(
  parameter int FLD_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             wr_i,
  input  logic             sin_i,
  input  logic [FLD_W-1:0] nib_i,
  output logic [FLD_W-1:0] q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (shift_i) q_o <= {q_o[FLD_W-2:0], sin_i};
    else if (wr_i)    q_o <= nib_i;
  end
endmodule

// File: rtl/xpt_cfg_dec.sv
module xpt_cfg_dec #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] addr_i,
  output logic [N_OUT-1:0] sel_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_dec
    assign sel_o[k] = en_i && (addr_i == SEL_W'(k));
  end
endmodule

// File: rtl/xpt_cfg_tap.sv
module xpt_cfg_tap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic track_i,
  input  logic msb_next_i,
  input  logic msb_i,
  input  logic park_i,
  output logic ser_o
);
  logic held_q;

  // follows the post-edge msb in serial mode, frozen in parallel mode
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= 1'b0;
    else if (track_i) held_q <= msb_next_i;
  end

  assign ser_o = park_i ? held_q : msb_i;
endmodule

// File: rtl/xpt_cfg_loader.sv
module xpt_cfg_loader
  import xpt_cfg_pkg::*;
#(
  parameter  int N_OUT  = XPT_NUM_OUT,
  localparam int SEL_W  = $clog2(N_OUT),
  localparam int FLD_W  = SEL_W + 1,
  localparam int WORD_W = N_OUT * FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              par_mode_i,
  input  logic              ser_i,
  input  logic [FLD_W-1:0]  nib_i,
  input  logic [SEL_W-1:0]  addr_i,
  output logic              ser_o,
  output logic [WORD_W-1:0] word_o
);
  load_mode_e mode;
  logic       shift_en;
  logic       par_en;
  logic [N_OUT-1:0] wr_sel;
  logic [N_OUT-1:0] chain;
  logic       msb_next;

  assign mode     = load_mode_e'(par_mode_i);
  assign shift_en = !ce_ni && (mode == LOAD_SER);
  assign par_en   = !ce_ni && (mode == LOAD_PAR);

  xpt_cfg_dec #(
    .N_OUT(N_OUT),
    .SEL_W(SEL_W)
  ) u_dec (
    .en_i  (par_en),
    .addr_i(addr_i),
    .sel_o (wr_sel)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_fld
    logic [FLD_W-1:0] q;
    xpt_cfg_field #(
      .FLD_W(FLD_W)
    ) u_fld (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift_en),
      .wr_i   (wr_sel[k]),
      .sin_i  (chain[k]),
      .nib_i  (nib_i),
      .q_o    (q)
    );
    assign word_o[k*FLD_W +: FLD_W] = q;
    if (k == 0) begin : g_head
      assign chain[k] = ser_i;
    end else begin : g_link
      assign chain[k] = word_o[k*FLD_W-1];
    end
  end

  // msb after the coming edge, used only while serial
  assign msb_next = shift_en ? word_o[WORD_W-2] : word_o[WORD_W-1];

  xpt_cfg_tap u_tap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .track_i   (mode == LOAD_SER),
    .msb_next_i(msb_next),
    .msb_i     (word_o[WORD_W-1]),
    .park_i    (mode == LOAD_PAR),
    .ser_o     (ser_o)
  );
endmodule

// File: rtl/xpt_cfg_loader_chk.sv
module xpt_cfg_loader_chk #(
  parameter int N_OUT  = 8,
  parameter int SEL_W  = 3,
  parameter int FLD_W  = 4,
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              par_mode_i,
  input logic              ser_i,
  input logic [FLD_W-1:0]  nib_i,
  input logic [SEL_W-1:0]  addr_i,
  input logic              ser_o,
  input logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] fmask;
  assign fmask = {{(WORD_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << (int'(addr_i) * FLD_W);

  // R1
  always_comb begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (word_o == '0 && ser_o == 1'b0);
    end
  end

  p_idle_hold_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (word_o == $past(word_o)) && (ser_o == $past(ser_o)));

  p_ser_shift_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !par_mode_i) |=> word_o == {$past(word_o[WORD_W-2:0]), $past(ser_i)});

  p_ser_tap_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !par_mode_i |-> ser_o == word_o[WORD_W-1]);

  p_par_write_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!ce_ni && par_mode_i) |=>
      (word_o[$past(addr_i)*FLD_W +: FLD_W] == $past(nib_i)) &&
      (((word_o ^ $past(word_o)) & ~$past(fmask)) == '0));

  p_par_park_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (par_mode_i && $past(par_mode_i)) |-> $stable(ser_o));
endmodule

bind xpt_cfg_loader xpt_cfg_loader_chk #(
  .N_OUT (N_OUT),
  .SEL_W (SEL_W),
  .FLD_W (FLD_W),
  .WORD_W(WORD_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .par_mode_i(par_mode_i),
  .ser_i     (ser_i),
  .nib_i     (nib_i),
  .addr_i    (addr_i),
  .ser_o     (ser_o),
  .word_o    (word_o)
);

// File: tb/sim_xpt_cfg_loader.sv
`timescale 1ns/1ps
module sim_xpt_cfg_loader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1;
  logic        par_mode_i = 1'b0;
  logic        ser_i = 1'b0;
  logic [3:0]  nib_i = '0;
  logic [2:0]  addr_i = '0;
  logic        ser_o;
  logic [31:0] word_o;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_w;
  logic        exp_s;

  xpt_cfg_loader u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .par_mode_i(par_mode_i),
    .ser_i(ser_i), .nib_i(nib_i), .addr_i(addr_i), .ser_o(ser_o), .word_o(word_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one falling edge, then sample after the next rising edge
  task automatic edge_step();
    @(negedge clk_i);
    @(posedge clk_i);
    #1;
  endtask

  task automatic ser_bit(input logic b);
    ce_ni = 1'b0; par_mode_i = 1'b0; ser_i = b;
    edge_step();
    exp_w = {exp_w[30:0], b};
    exp_s = exp_w[31];
  endtask

  task automatic par_wr(input logic [2:0] a, input logic [3:0] v);
    ce_ni = 1'b0; par_mode_i = 1'b1; addr_i = a; nib_i = v;
    edge_step();
    exp_w[a*4 +: 4] = v;
  endtask

  initial begin
    #800_000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pat_a;
    logic [31:0] pat_b;
    pat_a = 32'hA5C3_1E97;
    pat_b = 32'h3C69_F00D;
    exp_w = '0;
    exp_s = 1'b0;
    #3;
    chk("R1 word in reset", word_o, 32'h0);
    chk("R1 ser in reset", {31'h0, ser_o}, 32'h0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    edge_step();
    chk("R1 word after release", word_o, 32'h0);

    // R3/R5: load pat_a msb first
    for (int i = 31; i >= 0; i--) begin
      ser_bit(pat_a[i]);
      chk("R3 serial shift", word_o, exp_w);
    end
    chk("R5 field order", word_o, pat_a);
    chk("R5 field7 bit3 first", {31'h0, word_o[31]}, {31'h0, pat_a[31]});
    chk("R4 ser tap", {31'h0, ser_o}, {31'h0, pat_a[31]});

    // R4: pat_a streams out while pat_b goes in
    for (int i = 31; i >= 0; i--) begin
      ser_bit(pat_b[i]);
      chk("R4 ser stream", {31'h0, ser_o}, {31'h0, (i > 0) ? pat_a[i-1] : pat_b[31]});
    end
    chk("R5 second word", word_o, pat_b);

    // R2: chip enable high blocks both paths
    ce_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      par_mode_i = i[0]; ser_i = ~i[1]; addr_i = i[2:0]; nib_i = 4'(~i);
      edge_step();
      chk("R2 idle word", word_o, exp_w);
      chk("R2 idle ser", {31'h0, ser_o}, {31'h0, exp_s});
    end

    // R6/R7: every address with every value
    for (int a = 0; a < 8; a++) begin
      for (int v = 0; v < 16; v++) begin
        par_wr(3'(a), 4'(v ^ a));
        chk("R6 addressed write", word_o, exp_w);
        chk("R7 ser parked", {31'h0, ser_o}, {31'h0, exp_s});
      end
    end

    // R7: bit 31 flips under parallel write, ser_o must not follow
    par_wr(3'd7, {~exp_s, 3'b101});
    chk("R7 park vs msb", {31'h0, ser_o}, {31'h0, exp_s});
    chk("R6 field7 value", word_o, exp_w);

    // R4: back to serial, tap follows msb again
    ce_ni = 1'b1; par_mode_i = 1'b0;
    #1;
    chk("R4 tap on return", {31'h0, ser_o}, {31'h0, exp_w[31]});
    exp_s = exp_w[31];
    ser_bit(1'b1);
    chk("R3 shift after parallel", word_o, exp_w);
    chk("R4 tap after shift", {31'h0, ser_o}, {31'h0, exp_w[31]});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule